// File: doc/BRIEF.md
# Prioritized Autovectored Interrupt Controller

This block gathers interrupt request lines arranged into groups. Software gives each group one of four priority levels and a 14-bit handler offset. For each level, the block picks one winning group among the groups assigned to it that have a pending line. It then presents the highest level that the processor status does not mask. It also gives the winner's handler offset, and a handler address formed by bitwise OR of a processor-supplied base with that offset. Because the base and the offset are ORed rather than added, software must align the base so that none of its bits [13:0] overlap an offset in use.

Request lines are level-sensitive. They pass through one register stage before arbitration. A separate non-maskable input is registered the same way and drives its own output, whatever the masks say. A simple register port writes and reads the per-group priority registers. The same port reads the sampled request lines of each group and the per-level cause values.

Register address: `regAddr = {space[1:0], index}`. Space 0 holds the priority register of group `index`, readable and writable. Space 1 holds the sampled request lines of group `index`, read-only. Space 2 holds the cause of level `index[1:0]`, read-only. Space 3 reads zero.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset (synchronous, active high) is held and after it is released, every priority register reads 0 (level 0, offset 0), irqReq and nmiReq are 0, and every cause value is 0 until a request arrives.
- R2: Reading space 1 at a group returns that group's lines in bits [LINES-1:0] as sampled at the previous rising clock edge, with all other bits zero. A change on reqIn is visible one edge later and not before.
- R3: A priority register keeps the level in bits [31:30] and the offset in bits [13:0]. Written bits [29:14] are dropped and read back as zero. Writes to spaces 1 to 3 change no register.
- R4: A group is pending when any of its sampled lines is 1. A pending group competes only at the level held in its priority register.
- R5: When several pending groups share a level, the one with the highest group number wins. The cause of level L (space 2, index L, and causeOut bits [L*GIDX_W +: GIDX_W]) is the winner's group number, or 0 when no group is pending at L.
- R6: levelMask bit L set to 1 stops level L from driving irqReq. The cause of level L is still reported.
- R7: irqReq is 1 exactly when some unmasked level has a pending group. irqLevel is then the highest such level, where 3 is the highest and 0 the lowest.
- R8: handlerOffset is the offset of the winner at irqLevel, and handlerAddr equals vecBase bitwise-ORed with that offset zero-extended. Both are 0 and vecBase respectively when irqReq is 0.
- R9: nmiReq equals nmiIn as sampled at the previous rising edge, independent of levelMask and of the regular requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | GIDX_W+2 | Register address {space, index} |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| reqIn | input | GROUPS*LINES | Request lines, group g at bits [g*LINES +: LINES] |
| levelMask | input | 4 | Per-level mask from processor status, 1 = masked |
| nmiIn | input | 1 | Non-maskable request |
| vecBase | input | 32 | Handler base address |
| irqReq | output | 1 | A regular interrupt is presented |
| irqLevel | output | 2 | Level of the presented interrupt |
| handlerOffset | output | 14 | Offset of the winning group |
| handlerAddr | output | 32 | vecBase OR handlerOffset |
| nmiReq | output | 1 | Registered non-maskable request |
| causeOut | output | 4*GIDX_W | Per-level winning group numbers |

## Verification
On every cycle the assertions check these properties. A presented level is never masked. No unmasked level above it is pending. Any unmasked pending level raises irqReq. The idle offset is zero. A level with nothing pending reports cause 0. The non-maskable output follows its input one edge later. The scenarios must show the rest. These are the highest-number tie-break, the register field layout and dropped bits, the one-edge sampling delay of the request register, and that the handler address is an OR and not a sum (with a base that overlaps the offset). They also show that masking a level leaves its cause visible.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W = 2;
  localparam int OFF_W = 14;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SP_PRIO  = 2'd0,
    SP_REQ   = 2'd1,
    SP_CAUSE = 2'd2,
    SP_NONE  = 2'd3
  } regSpace_t;

  typedef struct packed {
    logic      prioWe;
    regSpace_t rdSpace;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int GIDX_W = 3
) (
  input  logic              regWe,
  input  logic [GIDX_W+1:0] regAddr,
  output ctrlStrobe_t       strobe,
  output logic [GIDX_W-1:0] regIdx
);
  regSpace_t space;

  always_comb begin
    space = regSpace_t'(regAddr[GIDX_W+1:GIDX_W]);
    regIdx = regAddr[GIDX_W-1:0];
    strobe.rdSpace = space;
    strobe.prioWe = regWe && (space == SP_PRIO);
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LINES = 4,
  parameter int GIDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStrobe_t                   strobe,
  input  logic [GIDX_W-1:0]             regIdx,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [GROUPS*LINES-1:0]       reqIn,
  input  logic [NUM_LEVELS-1:0]         levelMask,
  input  logic                          nmiIn,
  output logic                          irqReq,
  output logic [LVL_W-1:0]              irqLevel,
  output logic [OFF_W-1:0]              handlerOffset,
  output logic                          nmiReq,
  output logic [NUM_LEVELS-1:0]         levelPend,
  output logic [NUM_LEVELS*GIDX_W-1:0]  causeOut
);
  logic [LVL_W-1:0]  prioLvl [GROUPS];
  logic [OFF_W-1:0]  prioOff [GROUPS];
  logic [GROUPS*LINES-1:0] reqQ;
  logic nmiQ;
  logic [GROUPS-1:0] groupPend;
  logic [GIDX_W-1:0] levelWin [NUM_LEVELS];
  logic [OFF_W-1:0]  levelOff [NUM_LEVELS];

  // Request and NMI sampling stage
  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ <= '0;
      nmiQ <= 1'b0;
    end else begin
      reqQ <= reqIn;
      nmiQ <= nmiIn;
    end
  end

  assign nmiReq = nmiQ;

  // Priority registers
  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : gGroup
      always_ff @(posedge clk) begin
        if (rst) begin
          prioLvl[g] <= '0;
          prioOff[g] <= '0;
        end else if (strobe.prioWe && regIdx == GIDX_W'(g)) begin
          prioLvl[g] <= regWdata[DATA_W-1 -: LVL_W];
          prioOff[g] <= regWdata[OFF_W-1:0];
        end
      end
      assign groupPend[g] = |reqQ[g*LINES +: LINES];
    end
  endgenerate

  // Per-level arbitration: highest group number wins
  genvar lv;
  generate
    for (lv = 0; lv < NUM_LEVELS; lv++) begin : gLevel
      always_comb begin
        levelPend[lv] = 1'b0;
        levelWin[lv] = '0;
        levelOff[lv] = '0;
        for (int k = 0; k < GROUPS; k++) begin
          if (groupPend[k] && prioLvl[k] == LVL_W'(lv)) begin
            levelPend[lv] = 1'b1;
            levelWin[lv] = GIDX_W'(k);
            levelOff[lv] = prioOff[k];
          end
        end
      end
      assign causeOut[lv*GIDX_W +: GIDX_W] = levelWin[lv];
    end
  endgenerate

  // Highest unmasked level
  always_comb begin
    irqReq = 1'b0;
    irqLevel = '0;
    handlerOffset = '0;
    for (int k = 0; k < NUM_LEVELS; k++) begin
      if (levelPend[k] && !levelMask[k]) begin
        irqReq = 1'b1;
        irqLevel = LVL_W'(k);
        handlerOffset = levelOff[k];
      end
    end
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    case (strobe.rdSpace)
      SP_PRIO: begin
        regRdata[DATA_W-1 -: LVL_W] = prioLvl[regIdx];
        regRdata[OFF_W-1:0] = prioOff[regIdx];
      end
      SP_REQ:   regRdata[LINES-1:0] = reqQ[regIdx*LINES +: LINES];
      SP_CAUSE: regRdata[GIDX_W-1:0] = levelWin[regIdx[LVL_W-1:0]];
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LINES = 4,
  localparam int GIDX_W = (GROUPS < 4) ? 2 : $clog2(GROUPS),
  localparam int ADDR_W = GIDX_W + 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [31:0]                  regWdata,
  output logic [31:0]                  regRdata,
  input  logic [GROUPS*LINES-1:0]      reqIn,
  input  logic [3:0]                   levelMask,
  input  logic                         nmiIn,
  input  logic [31:0]                  vecBase,
  output logic                         irqReq,
  output logic [1:0]                   irqLevel,
  output logic [13:0]                  handlerOffset,
  output logic [31:0]                  handlerAddr,
  output logic                         nmiReq,
  output logic [4*GIDX_W-1:0]          causeOut
);
  ctrlStrobe_t strobe;
  logic [GIDX_W-1:0] regIdx;
  logic [NUM_LEVELS-1:0] levelPend;

  intc_ctrl #(.GIDX_W(GIDX_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .strobe(strobe), .regIdx(regIdx)
  );

  intc_datapath #(.GROUPS(GROUPS), .LINES(LINES), .GIDX_W(GIDX_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .reqIn(reqIn),
    .levelMask(levelMask), .nmiIn(nmiIn), .irqReq(irqReq),
    .irqLevel(irqLevel), .handlerOffset(handlerOffset), .nmiReq(nmiReq),
    .levelPend(levelPend), .causeOut(causeOut)
  );

  assign handlerAddr = vecBase | {{(32-OFF_W){1'b0}}, handlerOffset};
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int GIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        levelMask,
  input logic [3:0]        levelPend,
  input logic              irqReq,
  input logic [1:0]        irqLevel,
  input logic [13:0]       handlerOffset,
  input logic              nmiIn,
  input logic              nmiReq,
  input logic [4*GIDX_W-1:0] causeOut
);
  // R6
  masked_level_chk: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> !levelMask[irqLevel]);
  // R7
  highest_level_chk: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> ((levelPend & ~levelMask & (4'b1110 << irqLevel)) == 4'b0));
  // R7
  any_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((levelPend & ~levelMask) != 4'b0) |-> irqReq);
  // R8
  idle_offset_chk: assert property (@(posedge clk) disable iff (rst)
    !irqReq |-> handlerOffset == 14'd0);
  // R5
  empty_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !levelPend[3] |-> causeOut[3*GIDX_W +: GIDX_W] == '0);
  // R9
  nmi_follow_chk: assert property (@(posedge clk) disable iff (rst)
    nmiIn |=> nmiReq);
  // R9
  nmi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !nmiIn |=> !nmiReq);
endmodule

bind prio_vec_intc intc_chk #(.GIDX_W(GIDX_W)) u_chk (
  .clk(clk), .rst(rst), .levelMask(levelMask), .levelPend(levelPend),
  .irqReq(irqReq), .irqLevel(irqLevel), .handlerOffset(handlerOffset),
  .nmiIn(nmiIn), .nmiReq(nmiReq), .causeOut(causeOut)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  localparam int GROUPS = 8;
  localparam int LINES = 4;
  localparam int GW = 3;

  logic clk = 1'b0;
  logic rst;
  logic regWe;
  logic [GW+1:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic [GROUPS*LINES-1:0] reqIn;
  logic [3:0] levelMask;
  logic nmiIn;
  logic [31:0] vecBase;
  logic irqReq;
  logic [1:0] irqLevel;
  logic [13:0] handlerOffset;
  logic [31:0] handlerAddr;
  logic nmiReq;
  logic [4*GW-1:0] causeOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_vec_intc #(.GROUPS(GROUPS), .LINES(LINES)) dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqIn(reqIn),
    .levelMask(levelMask), .nmiIn(nmiIn), .vecBase(vecBase),
    .irqReq(irqReq), .irqLevel(irqLevel), .handlerOffset(handlerOffset),
    .handlerAddr(handlerAddr), .nmiReq(nmiReq), .causeOut(causeOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rdReg(input logic [1:0] sp, input int idx, output logic [31:0] d);
    regAddr = {sp, GW'(idx)};
    #1 d = regRdata;
  endtask

  task automatic wrPrio(input int g, input logic [31:0] d);
    regWe = 1'b1;
    regAddr = {2'd0, GW'(g)};
    regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic setGrp(input int g, input logic [LINES-1:0] v);
    reqIn[g*LINES +: LINES] = v;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 irqReq", 32'(irqReq), 0);
    chk("R1 nmiReq", 32'(nmiReq), 0);
    chk("R1 causeOut", 32'(causeOut), 0);
    rdReg(2'd0, 5, d);
    chk("R1 prio reg g5", d, 0);
  endtask

  task automatic testPrioLayout();
    logic [31:0] d;
    wrPrio(2, 32'h7FFF_F230);
    rdReg(2'd0, 2, d);
    chk("R3 prio layout g2", d, 32'h4000_3230);
    regWe = 1'b1; regAddr = {2'd2, 3'd2}; regWdata = 32'hFFFF_FFFF;
    step();
    regWe = 1'b0;
    rdReg(2'd0, 2, d);
    chk("R3 write to cause space ignored", d, 32'h4000_3230);
  endtask

  task automatic testReqReg();
    logic [31:0] d;
    setGrp(2, 4'b1010);
    rdReg(2'd1, 2, d);
    chk("R2 req reg before edge", d, 0);
    step();
    rdReg(2'd1, 2, d);
    chk("R2 req reg after edge", d, 32'hA);
  endtask

  task automatic testSingle();
    vecBase = 32'h8000_0010;
    #1;
    chk("R4 irqReq single", 32'(irqReq), 1);
    chk("R4 level single", 32'(irqLevel), 1);
    chk("R8 offset", 32'(handlerOffset), 32'h3230);
    chk("R8 OR address", handlerAddr, 32'h8000_3230);
    chk("R5 cause L1", 32'(causeOut[GW +: GW]), 2);
  endtask

  task automatic testTie();
    logic [31:0] d;
    wrPrio(1, 32'h8000_0040);
    wrPrio(5, 32'h8000_0100);
    wrPrio(6, 32'h8000_0200);
    setGrp(1, 4'b0001); setGrp(5, 4'b0100); setGrp(6, 4'b1000);
    step();
    chk("R5 tie winner level", 32'(irqLevel), 2);
    chk("R5 tie winner offset", 32'(handlerOffset), 32'h200);
    rdReg(2'd2, 2, d);
    chk("R5 cause reg L2", d, 6);
    setGrp(6, 4'b0000);
    step();
    chk("R5 next winner cause", 32'(causeOut[2*GW +: GW]), 5);
    chk("R5 next winner offset", 32'(handlerOffset), 32'h100);
  endtask

  task automatic testMask();
    levelMask = 4'b0100;
    #1;
    chk("R6 masked L2 falls to L1", 32'(irqLevel), 1);
    chk("R6 masked L2 cause kept", 32'(causeOut[2*GW +: GW]), 5);
    levelMask = 4'b1111;
    #1;
    chk("R7 all masked irqReq", 32'(irqReq), 0);
    chk("R8 idle offset", 32'(handlerOffset), 0);
  endtask

  task automatic testNmi();
    nmiIn = 1'b1;
    #1;
    chk("R9 nmi before edge", 32'(nmiReq), 0);
    step();
    chk("R9 nmi under full mask", 32'(nmiReq), 1);
    nmiIn = 1'b0;
    step();
    chk("R9 nmi released", 32'(nmiReq), 0);
  endtask

  task automatic testTop();
    logic [31:0] d;
    levelMask = 4'b0000;
    wrPrio(7, 32'hC000_0800);
    setGrp(7, 4'b0010);
    step();
    chk("R7 level 3 wins", 32'(irqLevel), 3);
    chk("R8 level 3 address", handlerAddr, 32'h8000_0810);
    chk("R5 cause L3", 32'(causeOut[3*GW +: GW]), 7);
    rdReg(2'd2, 0, d);
    chk("R5 empty level cause", d, 0);
  endtask

  initial begin
    rst = 1'b1; regWe = 1'b0; regAddr = '0; regWdata = '0;
    reqIn = '0; levelMask = 4'b0000; nmiIn = 1'b0; vecBase = '0;
    repeat (3) step();
    testReset();
    rst = 1'b0;
    step();
    testReset();
    testPrioLayout();
    testReqReg();
    testSingle();
    testTie();
    testMask();
    testNmi();
    testTop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule